// File: doc/BRIEF.md
# Load/Store Ordering Matrix

This block keeps memory operations from several load/store units in a safe order. It lets operations of one kind run together and holds back operations of the other kind. Each unit issues one operation at a time, marked as a load or a store. While the operation is outstanding it is recorded as pending. When the unit finishes, a completion strobe releases it. Every later operation of the opposite kind is made to wait until all earlier pending operations of the other kind have completed.

Inside sits a square grid of hazard cells, one row and one column for each unit. Cell (i,j) holds two flags. A read-after-write flag is set when unit i starts a load while unit j holds a store. A write-after-read flag is set when unit i starts a store while unit j holds a load. A unit's load or store may go ahead only when its row holds no hazard flag of the matching kind. As a result, only groups made entirely of loads, or entirely of stores, move at once, and the order between such groups is kept. Addresses are never compared; spotting overlapping addresses is left to other logic.

Top module: `mem_order_matrix`

## Requirements
- R1: After synchronous reset, every `ld_go` and `st_go` bit is 0 and no unit is pending.
- R2: An issue to an idle unit is accepted at the clock edge where it is sampled. `issue_store` = 0 means a load and 1 means a store. If no hazard applies, the unit's `ld_go` (for a load) or `st_go` (for a store) reads 1 from the next cycle on. A unit never shows `ld_go` and `st_go` together.
- R3: A load accepted in unit i while another unit j holds a pending store keeps `ld_go[i]` at 0 until every such store has completed. The cycle after the last of them completes, `ld_go[i]` becomes 1.
- R4: A store accepted in unit i while another unit j holds a pending load keeps `st_go[i]` at 0 until every such load has completed. The cycle after the last of them completes, `st_go[i]` becomes 1.
- R5: Operations of the same kind never block one another. Several loads, or several stores, may all show their go flag at the same time.
- R6: A completion strobe on a busy unit ends its operation. Its go flags read 0 from the next cycle, and the hazards that it caused in other rows are cleared in the same edge.
- R7: When units of opposite kinds issue in the same cycle into an idle matrix, the unit with the lower index is treated as the older one. Only the higher-index unit is held back.
- R8: An issue to a unit that is busy and not completing in that cycle is ignored: its pending kind and its go flags are unchanged. A completion strobe on an idle unit has no effect.
- R9: If unit j completes in the same cycle that unit i issues, the operation that unit j finished creates no hazard for unit i.
- R10: A unit that completes and issues in the same cycle takes the new operation. Its go flag for the new kind follows the rules of R2 to R4 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | N_UNITS | Per-unit issue strobe |
| issue_store | input | N_UNITS | Kind of the issued operation: 0 = load, 1 = store |
| done_vld | input | N_UNITS | Per-unit completion strobe |
| ld_go | output | N_UNITS | Unit's pending load may proceed |
| st_go | output | N_UNITS | Unit's pending store may proceed |

## Verification
The state is sampled at one clock edge, and the go flags are decoded from registers with no further delay. So every effect of an issue or completion strobe is due exactly one cycle later. The bench drives each set of strobes on a falling edge and lets one rising edge pass. It compares both go vectors on the following falling edge, before it drives the next stimulus. Directed sequences cover the ordering cases. A long pseudo-random sweep over four units compares every cycle against a reference computed from the requirements.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } mem_op_e;

    typedef struct packed {
        logic    busy;
        mem_op_e op;
    } unit_state_t;

    localparam unit_state_t UNIT_IDLE = '{busy: 1'b0, op: OP_LOAD};

    // A unit takes a new operation when idle or when finishing this cycle
    function automatic logic can_accept(input unit_state_t s, input logic fin);
        return !s.busy || fin;
    endfunction

    // Pending kind after this cycle's completion is applied
    function automatic logic holds_op(input unit_state_t s, input logic fin,
                                      input mem_op_e kind);
        return s.busy && !fin && (s.op == kind);
    endfunction

endpackage

// File: rtl/mem_order_unit.sv
module mem_order_unit
    import mem_order_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue,
    input  logic        is_store,
    input  logic        fin,
    output logic        accept,
    output unit_state_t state
);

    unit_state_t state_q;

    assign accept = issue && can_accept(state_q, fin);
    assign state  = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UNIT_IDLE;
        end else if (accept) begin
            state_q.busy <= 1'b1;
            state_q.op   <= is_store ? OP_STORE : OP_LOAD;
        end else if (fin) begin
            state_q <= UNIT_IDLE;
        end
    end

    // R8: a busy unit that is not finishing keeps its operation kind
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q.busy && !fin) |=> (state_q.busy && $stable(state_q.op)));

    // R6: finishing without a new issue leaves the unit idle
    p_fin_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (fin && !issue) |=> !state_q.busy);

endmodule

// File: rtl/mem_order_cell.sv
module mem_order_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_raw,
    input  logic set_war,
    input  logic clear,
    output logic raw,
    output logic war
);

    logic raw_q, war_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            war_q <= 1'b0;
        end else begin
            if (set_raw)    raw_q <= 1'b1;
            else if (clear) raw_q <= 1'b0;
            if (set_war)    war_q <= 1'b1;
            else if (clear) war_q <= 1'b0;
        end
    end

    assign raw = raw_q;
    assign war = war_q;

    // R5: a cell never holds both hazard kinds at once
    p_one_kind_r5: assert property (@(posedge clk) disable iff (rst)
        !(raw_q && war_q));

endmodule

// File: rtl/mem_order_matrix.sv
module mem_order_matrix
    import mem_order_pkg::*;
#(
    parameter int N_UNITS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_UNITS-1:0] issue_vld,
    input  logic [N_UNITS-1:0] issue_store,
    input  logic [N_UNITS-1:0] done_vld,
    output logic [N_UNITS-1:0] ld_go,
    output logic [N_UNITS-1:0] st_go
);

    localparam int LAST = N_UNITS - 1;

    unit_state_t                   ustate [N_UNITS];
    logic [N_UNITS-1:0]            acc;
    logic [N_UNITS-1:0]            left_ld;
    logic [N_UNITS-1:0]            left_st;
    logic [N_UNITS-1:0]            new_ld;
    logic [N_UNITS-1:0]            new_st;
    logic [LAST:0][LAST:0]         raw_m;
    logic [LAST:0][LAST:0]         war_m;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        mem_order_unit u_unit (
            .clk      (clk),
            .rst      (rst),
            .issue    (issue_vld[u]),
            .is_store (issue_store[u]),
            .fin      (done_vld[u]),
            .accept   (acc[u]),
            .state    (ustate[u])
        );
        assign left_ld[u] = holds_op(ustate[u], done_vld[u], OP_LOAD);
        assign left_st[u] = holds_op(ustate[u], done_vld[u], OP_STORE);
        assign new_ld[u]  = acc[u] && !issue_store[u];
        assign new_st[u]  = acc[u] &&  issue_store[u];
    end

    for (genvar r = 0; r < N_UNITS; r++) begin : g_row
        for (genvar c = 0; c < N_UNITS; c++) begin : g_col
            if (r == c) begin : g_diag
                assign raw_m[r][c] = 1'b0;
                assign war_m[r][c] = 1'b0;
            end else begin : g_cell
                // Lower index counts as older when both issue together
                localparam bit COL_OLDER = (c < r);
                logic st_ahead, ld_ahead;
                assign st_ahead = left_st[c] || (COL_OLDER && new_st[c]);
                assign ld_ahead = left_ld[c] || (COL_OLDER && new_ld[c]);

                mem_order_cell u_cell (
                    .clk     (clk),
                    .rst     (rst),
                    .set_raw (new_ld[r] && st_ahead),
                    .set_war (new_st[r] && ld_ahead),
                    .clear   (done_vld[r] || done_vld[c] || acc[r]),
                    .raw     (raw_m[r][c]),
                    .war     (war_m[r][c])
                );

                // R3: a read-after-write flag only stands against a held store
                p_raw_src_r3: assert property (@(posedge clk) disable iff (rst)
                    raw_m[r][c] |-> (ustate[c].busy && ustate[c].op == OP_STORE
                                     && ustate[r].busy && ustate[r].op == OP_LOAD));

                // R4: a write-after-read flag only stands against a held load
                p_war_src_r4: assert property (@(posedge clk) disable iff (rst)
                    war_m[r][c] |-> (ustate[c].busy && ustate[c].op == OP_LOAD
                                     && ustate[r].busy && ustate[r].op == OP_STORE));

                // R6: finishing unit c leaves no hazard against it
                p_col_clear_r6: assert property (@(posedge clk) disable iff (rst)
                    (done_vld[c] && !acc[c]) |=> (!raw_m[r][c] && !war_m[r][c]));
            end
        end

        assign ld_go[r] = ustate[r].busy && ustate[r].op == OP_LOAD  && !(|raw_m[r]);
        assign st_go[r] = ustate[r].busy && ustate[r].op == OP_STORE && !(|war_m[r]);

        // R2: never both go flags for one unit
        p_go_excl_r2: assert property (@(posedge clk) disable iff (rst)
            !(ld_go[r] && st_go[r]));

        // R6: finishing without reissue drops both go flags next cycle
        p_fin_drop_r6: assert property (@(posedge clk) disable iff (rst)
            (done_vld[r] && !issue_vld[r]) |=> (!ld_go[r] && !st_go[r]));
    end

    // R1: nothing may proceed in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (ld_go == '0 && st_go == '0));

    // R5: loads and stores never proceed at the same time
    p_batch_pure_r5: assert property (@(posedge clk) disable iff (rst)
        !((|ld_go) && (|st_go)));

endmodule

// File: tb/mem_order_matrix_tb_top.sv
module mem_order_matrix_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] issue_vld, issue_store, done_vld;
    logic [N-1:0] ld_go, st_go;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mem_order_matrix #(.N_UNITS(N)) dut_i (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .issue_store(issue_store),
        .done_vld(done_vld), .ld_go(ld_go), .st_go(st_go)
    );

    // Reference state built from the requirements
    bit m_busy [N];
    bit m_st   [N];
    bit m_raw  [N][N];
    bit m_war  [N][N];

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_st[i] = 0;
            for (int j = 0; j < N; j++) begin m_raw[i][j] = 0; m_war[i][j] = 0; end
        end
    endfunction

    function automatic void model_step(input logic [N-1:0] iv, input logic [N-1:0] is,
                                       input logic [N-1:0] dn);
        bit acc [N];
        bit pb  [N];
        bit nr [N][N];
        bit nw [N][N];
        for (int i = 0; i < N; i++) begin
            acc[i] = iv[i] && (!m_busy[i] || dn[i]);   // R8, R10
            pb[i]  = m_busy[i] && !dn[i];              // R9
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                bit st_ahead, ld_ahead;
                st_ahead = (pb[j] && m_st[j])  || (acc[j] && is[j]  && j < i); // R7
                ld_ahead = (pb[j] && !m_st[j]) || (acc[j] && !is[j] && j < i);
                nr[i][j] = m_raw[i][j]; nw[i][j] = m_war[i][j];
                if (dn[i] || dn[j] || acc[i]) begin nr[i][j] = 0; nw[i][j] = 0; end
                if (i != j && acc[i] && !is[i] && st_ahead) nr[i][j] = 1;
                if (i != j && acc[i] &&  is[i] && ld_ahead) nw[i][j] = 1;
            end
        for (int i = 0; i < N; i++) begin
            if (acc[i]) begin m_busy[i] = 1; m_st[i] = is[i]; end
            else if (dn[i]) m_busy[i] = 0;
            for (int j = 0; j < N; j++) begin m_raw[i][j] = nr[i][j]; m_war[i][j] = nw[i][j]; end
        end
    endfunction

    function automatic logic [N-1:0] model_ld();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            bit blk = 0;
            for (int j = 0; j < N; j++) blk |= m_raw[i][j];
            v[i] = m_busy[i] && !m_st[i] && !blk;
        end
        return v;
    endfunction

    function automatic logic [N-1:0] model_st();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            bit blk = 0;
            for (int j = 0; j < N; j++) blk |= m_war[i][j];
            v[i] = m_busy[i] && m_st[i] && !blk;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [N-1:0] exp_ld,
                         input logic [N-1:0] exp_st);
        checks++;
        if (ld_go !== exp_ld || st_go !== exp_st) begin
            fails++;
            $display("FAIL %s: ld_go=%b st_go=%b expected ld_go=%b st_go=%b",
                     req, ld_go, st_go, exp_ld, exp_st);
        end
    endtask

    // Drive on falling edge, pass one rising edge, sample at next falling edge
    task automatic step(input logic [N-1:0] iv, input logic [N-1:0] is,
                        input logic [N-1:0] dn);
        issue_vld = iv; issue_store = is; done_vld = dn;
        model_step(iv, is, dn);
        @(negedge clk);
        issue_vld = '0; issue_store = '0; done_vld = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; issue_vld = '0; issue_store = '0; done_vld = '0;
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int unsigned lfsr;
        @(negedge clk);
        do_reset();
        check("R1", '0, '0);

        // R2: a lone load and a lone store
        step(4'b0001, 4'b0000, 4'b0000); check("R2", 4'b0001, 4'b0000);
        step(4'b0000, 4'b0000, 4'b0001); check("R6", 4'b0000, 4'b0000);
        step(4'b0100, 4'b0100, 4'b0000); check("R2", 4'b0000, 4'b0100);

        // R3: load behind store in unit 2
        step(4'b0010, 4'b0000, 4'b0000); check("R3", 4'b0000, 4'b0100);
        // R8: reissue to busy unit 1 as a store is ignored
        step(4'b0010, 4'b0010, 4'b0000); check("R8", 4'b0000, 4'b0100);
        // R8: completion on idle unit 3 changes nothing
        step(4'b0000, 4'b0000, 4'b1000); check("R8", 4'b0000, 4'b0100);
        // R5: second load joins batch; both wait on the store
        step(4'b1000, 4'b0000, 4'b0000); check("R5", 4'b0000, 4'b0100);
        step(4'b0000, 4'b0000, 4'b0100); check("R3", 4'b1010, 4'b0000);

        // R4: store behind both loads
        step(4'b0001, 4'b0001, 4'b0000); check("R4", 4'b1010, 4'b0000);
        step(4'b0000, 4'b0000, 4'b0010); check("R4", 4'b1000, 4'b0000);
        step(4'b0000, 4'b0000, 4'b1000); check("R4", 4'b0000, 4'b0001);
        step(4'b0000, 4'b0000, 4'b0001); check("R6", 4'b0000, 4'b0000);

        // R7: simultaneous opposite kinds, lower index older
        step(4'b0011, 4'b0001, 4'b0000); check("R7", 4'b0000, 4'b0001);
        step(4'b0000, 4'b0000, 4'b0001); check("R7", 4'b0010, 4'b0000);
        // R9: unit 1 finishes while unit 2 issues a store
        step(4'b0100, 4'b0100, 4'b0010); check("R9", 4'b0000, 4'b0100);
        // R10: unit 2 finishes and reissues as a load
        step(4'b0100, 4'b0000, 4'b0100); check("R10", 4'b0100, 4'b0000);
        // R5: batch of stores in units 0 and 1 behind the load
        step(4'b0011, 4'b0011, 4'b0000); check("R5", 4'b0100, 4'b0000);
        step(4'b0000, 4'b0000, 4'b0100); check("R5", 4'b0000, 4'b0011);
        do_reset();
        check("R1", '0, '0);

        // Pseudo-random sweep against the reference
        lfsr = 32'h1ACE_B00C;
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] iv, is, dn;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            iv = lfsr[3:0] & lfsr[7:4];
            is = lfsr[11:8];
            dn = lfsr[15:12] & lfsr[19:16];
            step(iv, is, dn);
            check("R2-sweep R3 R4 R6 R7 R9 R10", model_ld(), model_st());
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule